// File: doc/BRIEF.md
# Whole-Method Instruction Cache

This block keeps the code of exactly one method in on-chip RAM. The processor presents a call or return request that carries the method's start word address in main memory, its length in 32-bit words and the byte offset where execution continues. If that method is already resident, the request completes at once. Otherwise the block copies the whole method body, word by word, from a simple read port on main memory, and holds `busy` high until the last word is stored.

Between requests, bytecodes are fetched with method-relative byte offsets that index the RAM directly. No tag lookup and no address translation happen on these fetches. Misses can therefore occur only on a call or a return, so the fetch timing inside a method is fixed. A method that is empty or larger than the RAM raises an error flag and is not loaded.

Top module: `method_cache`

## Requirements
- R1: After reset, `busy`, `err` and `mem_rd` are 0 and no method is resident, so the first acceptable request is a miss.
- R2: A request with `busy` low, an acceptable length and a start address other than the resident one raises `busy` in the next cycle. The block then reads addresses start, start+1, … start+len-1 in order, holding each address on `mem_addr` with `mem_rd` high until a cycle with `mem_ack` high. `busy` falls in the cycle after the last acknowledged word.
- R3: A request for the start address of the resident method causes no memory read and leaves `busy` low.
- R4: `bc_data` is valid one cycle after `bc_addr` is set. It returns the byte at that method-relative offset, where byte offset 4w+b is bits [31-8b -: 8] of method word w.
- R5: One cycle after any acceptable request is taken, `resume_off` equals the request's `req_off`.
- R6: A request with length 0 or a length above MAX_WORDS (256) sets `err` and reads no memory. The resident method stays resident. The next acceptable request clears `err`.
- R7: Requests that arrive while `busy` is high are ignored.
- R8: Loading a new method evicts the previous one, so a later request for the old method is a miss again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Call/return request strobe |
| req_addr | input | 24 | Method start word address in main memory |
| req_len | input | 9 | Method length in 32-bit words |
| req_off | input | 10 | Method-relative byte offset to resume at |
| busy | output | 1 | Method load in progress |
| err | output | 1 | Last request had an unacceptable length |
| resume_off | output | 10 | Offset latched from the last acceptable request |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory word address |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory data valid for the current address |
| bc_addr | input | 10 | Bytecode fetch byte offset within the method |
| bc_data | output | 8 | Fetched bytecode (one cycle latency) |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a fill. That request must neither disturb the address sequence nor change which method ends up resident. The bench starts a long load under random memory latency, injects a conflicting request while `busy` is high, and then proves that the original method is resident by a hit that causes no memory reads. Evictions and hits are produced by random calls among three methods, which are tracked in a bench model of the resident method. Error-length requests are placed between loads to show that the resident method survives them.

// File: rtl/method_cache.sv
module method_cache #(
  parameter int ADDR_W    = 24,
  parameter int MAX_WORDS = 256
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic [ADDR_W-1:0]                  req_addr,
  input  logic [$clog2(MAX_WORDS):0]         req_len,
  input  logic [$clog2(MAX_WORDS)+1:0]       req_off,
  output logic                               busy,
  output logic                               err,
  output logic [$clog2(MAX_WORDS)+1:0]       resume_off,
  output logic                               mem_rd,
  output logic [ADDR_W-1:0]                  mem_addr,
  input  logic [31:0]                        mem_rdata,
  input  logic                               mem_ack,
  input  logic [$clog2(MAX_WORDS)+1:0]       bc_addr,
  output logic [7:0]                         bc_data
);
  localparam int WIDX_W = $clog2(MAX_WORDS);
  localparam int LEN_W  = WIDX_W + 1;

  logic [31:0]       ram [MAX_WORDS];
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_vld;
  logic [LEN_W-1:0]  cnt, fill_len;
  logic [31:0]       rd_word;
  logic [1:0]        rd_sel;

  wire take    = req_valid & ~busy;
  wire len_bad = (req_len == '0) || (req_len > LEN_W'(MAX_WORDS));
  wire hit     = cur_vld && (cur_addr == req_addr);
  wire last    = (cnt == fill_len - LEN_W'(1));

  assign mem_rd   = busy;
  assign mem_addr = cur_addr + ADDR_W'(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      err        <= 1'b0;
      cur_vld    <= 1'b0;
      cur_addr   <= '0;
      cnt        <= '0;
      fill_len   <= '0;
      resume_off <= '0;
    end else if (take) begin
      if (len_bad) begin
        err <= 1'b1;
      end else begin
        err        <= 1'b0;
        resume_off <= req_off;
        if (!hit) begin
          busy     <= 1'b1;
          cur_vld  <= 1'b0;
          cur_addr <= req_addr;
          fill_len <= req_len;
          cnt      <= '0;
        end
      end
    end else if (busy && mem_ack) begin
      cnt <= cnt + LEN_W'(1);
      if (last) begin
        busy    <= 1'b0;
        cur_vld <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && mem_ack) ram[cnt[WIDX_W-1:0]] <= mem_rdata;
    rd_word <= ram[bc_addr[WIDX_W+1:2]];
    rd_sel  <= bc_addr[1:0];
  end

  always_comb begin
    case (rd_sel)
      2'd0:    bc_data = rd_word[31:24];
      2'd1:    bc_data = rd_word[23:16];
      2'd2:    bc_data = rd_word[15:8];
      default: bc_data = rd_word[7:0];
    endcase
  end
endmodule

module method_cache_chk #(
  parameter int ADDR_W    = 24,
  parameter int MAX_WORDS = 256
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic [ADDR_W-1:0]            req_addr,
  input logic [$clog2(MAX_WORDS):0]   req_len,
  input logic [$clog2(MAX_WORDS)+1:0] req_off,
  input logic                         busy,
  input logic                         err,
  input logic [$clog2(MAX_WORDS)+1:0] resume_off,
  input logic                         mem_rd,
  input logic [ADDR_W-1:0]            mem_addr,
  input logic                         mem_ack,
  input logic                         cur_vld,
  input logic [ADDR_W-1:0]            cur_addr
);
  localparam int LEN_W = $clog2(MAX_WORDS) + 1;
  wire bad   = (req_len == '0) || (req_len > LEN_W'(MAX_WORDS));
  wire taken = req_valid && !busy;
  wire res   = cur_vld && (cur_addr == req_addr);

  p_miss_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !bad && !res) |=> busy);
  p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> $stable(mem_addr));
  p_hit_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !bad && res) |=> (!busy && !mem_rd));
  p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !bad) |=> (resume_off == $past(req_off)));
  p_bad_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && bad) |=> (err && !busy));
endmodule

bind method_cache method_cache_chk #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_len(req_len), .req_off(req_off), .busy(busy), .err(err),
  .resume_off(resume_off), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .cur_vld(cur_vld), .cur_addr(cur_addr)
);

// File: tb/sim_method_cache.sv
module sim_method_cache;
  localparam int AW = 24, MW = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [8:0] req_len = '0;
  logic [9:0] req_off = '0, resume_off, bc_addr = '0;
  logic busy, err, mem_rd, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [7:0] bc_data;

  int checks = 0, failures = 0;
  int acks = 0, seq_err = 0, fill_len = 0;
  logic [AW-1:0] fill_base = '0;
  bit last_flag = 0, done = 0;

  always #5 clk = ~clk;

  method_cache #(.ADDR_W(AW), .MAX_WORDS(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_off(req_off), .busy(busy), .err(err),
    .resume_off(resume_off), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .bc_addr(bc_addr), .bc_data(bc_data));

  function automatic logic [31:0] mfun(logic [AW-1:0] a);
    return ({8'd0, a} * 32'h9E3779B1) ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [7:0] exp_byte(logic [AW-1:0] base, int off);
    logic [31:0] w = mfun(base + AW'(off / 4));
    return w[31 - 8*(off % 4) -: 8];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder with random latency
  initial begin
    forever begin
      @(negedge clk);
      if (last_flag) begin
        check(busy == 1'b0, "R2 busy falls after last word", busy, 0);
        last_flag = 0;
      end
      if (mem_rd) begin
        if (mem_addr != fill_base + AW'(acks)) seq_err++;
        mem_ack = ($urandom % 3) != 0;
        if (mem_ack) begin
          mem_rdata = mfun(mem_addr);
          acks++;
          if (acks == fill_len) last_flag = 1;
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic do_req(logic [AW-1:0] a, int len, int off);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = 9'(len); req_off = 10'(off);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic call(logic [AW-1:0] a, int len, int off, bit exp_hit, string tag);
    int waitc = 0;
    fill_base = a; fill_len = exp_hit ? 0 : len; acks = 0; seq_err = 0;
    do_req(a, len, off);
    check(busy == !exp_hit, {tag, " busy after request"}, busy, !exp_hit);
    while (busy && waitc < 5000) begin @(negedge clk); waitc++; end
    repeat (2) @(negedge clk);
    check(acks == fill_len, {tag, " word reads"}, acks, fill_len);
    check(seq_err == 0, {tag, " R2 address order"}, seq_err, 0);
    check(resume_off == 10'(off), {tag, " R5 resume offset"}, resume_off, off);
    check(err == 1'b0, {tag, " R6 err cleared"}, err, 0);
  endtask

  task automatic rd_byte(logic [AW-1:0] base, int off);
    @(negedge clk); bc_addr = 10'(off);
    @(negedge clk);
    check(bc_data == exp_byte(base, off), "R4 bytecode read", bc_data, exp_byte(base, off));
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 200000) begin @(posedge clk); wd++; end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] maddr [3];
    int mlen [3];
    int res;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0, "R1 busy at reset", busy, 0);
    check(err == 0, "R1 err at reset", err, 0);
    check(mem_rd == 0, "R1 mem_rd at reset", mem_rd, 0);

    // R1: first request is a miss even at address 0
    call(24'h000000, 3, 5, 0, "R1 first miss");
    rd_byte(24'h000000, 0); rd_byte(24'h000000, 5); rd_byte(24'h000000, 11);

    // R2 boundary: maximum-size method
    call(24'h001000, MW, 1020, 0, "R2 max length");
    rd_byte(24'h001000, 1023); rd_byte(24'h001000, 512);

    // R6: bad lengths leave resident method and read nothing
    acks = 0; fill_len = 0;
    do_req(24'h002000, MW + 1, 7);
    check(err == 1 && busy == 0, "R6 oversize err", {err, busy}, 2'b10);
    check(resume_off == 10'd1020, "R6 resume untouched", resume_off, 1020);
    do_req(24'h002000, 0, 7);
    check(err == 1, "R6 zero length err", err, 1);
    repeat (3) @(negedge clk);
    check(acks == 0, "R6 no memory reads", acks, 0);
    call(24'h001000, MW, 9, 1, "R3 R6 hit after error");
    rd_byte(24'h001000, 700);

    // R7: request during a fill is ignored
    fill_base = 24'h003000; fill_len = 40; acks = 0; seq_err = 0;
    do_req(24'h003000, 40, 2);
    repeat (5) @(negedge clk);
    check(busy == 1, "R7 still filling", busy, 1);
    do_req(24'h004000, 10, 3);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(acks == 40 && seq_err == 0, "R7 fill undisturbed", acks, 40);
    check(resume_off == 10'd2, "R7 offset kept", resume_off, 2);
    call(24'h003000, 40, 4, 1, "R7 original resident");
    rd_byte(24'h003000, 159);

    // R8: eviction
    call(24'h000000, 3, 1, 0, "R8 evict");
    call(24'h003000, 40, 4, 0, "R8 old method reloads");

    // random calls among three methods
    for (int i = 0; i < 3; i++) begin
      maddr[i] = AW'($urandom % 24'hFFFF00) + 24'h100;
      mlen[i]  = 1 + ($urandom % MW);
    end
    res = -1;
    for (int n = 0; n < 24; n++) begin
      int k = $urandom % 3;
      int off = $urandom % (mlen[k] * 4);
      call(maddr[k], mlen[k], off, (res == k) ? 1'b1 : 1'b0, "R2 R3 random call");
      res = k;
      for (int j = 0; j < 3; j++) rd_byte(maddr[k], $urandom % (mlen[k] * 4));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule